// File: doc/BRIEF.md
# Configurable Video Pixel Output Formatter

This block sits at the output edge of a video capture pipeline. Each cycle of the 2x pixel clock it takes one sample set: luma and both chroma components, or red, green and blue. Alongside the samples come the blanking, VBI-valid, horizontal sync, vertical sync and field qualifiers. It packs the samples onto a 16-bit pixel bus in one of four layouts. The layouts are 8-bit multiplexed 4:2:2 YCbCr, 16-bit 4:2:2 YCbCr, 15-bit RGB 5:5:5 and 16-bit RGB 5:6:5, and a 2-bit format input selects between them. Component inputs are `COMP_W` bits wide, and each layout keeps only their most significant bits.

A two-bit sample phase decides which component goes onto a multiplexed lane. The phase counts on every clock. It restarts at zero on the first sample after blanking ends, so every active line opens with Cb. During blanking the bus carries fixed black and neutral codes, unless the VBI-valid qualifier says ancillary data is present. In that case the samples are packed as usual.

A data-valid output marks active video. A configuration input selects its form. It is either a plain registered level, or that same level ANDed with the 2x clock so that downstream logic sees a gated clock. All data and qualifier outputs come from a single register stage on the rising clock edge.

Top module: `pix_out_fmt`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs go to `pix_out`=0, `blank_out`=1, `hsync_out`=`vsync_out`=`field_out`=0 and `dvalid`=0. The sample phase goes to 0 and the previous-blank state goes to 1.
- R2: With `fmt_sel`=0 (8-bit YCbCr), `pix_out[15:8]` carries one component chosen by the phase: phase 0 Cb, 1 Y, 2 Cr, 3 Y. `pix_out[7:0]` is 0.
- R3: The phase used for a sample is 0 when `blank_in` was high on the previous cycle (or reset was active) and is low now. Otherwise it is the previous sample's phase plus one, modulo 4, and this counting continues through blanking and format changes.
- R4: With `fmt_sel`=1 (16-bit YCbCr), `pix_out[15:8]` carries Y. `pix_out[7:0]` carries Cb when the phase is even and Cr when it is odd.
- R5: With `fmt_sel`=2 (RGB 5:5:5), `pix_out` = {0, R[msb 5], G[msb 5], B[msb 5]}. Blue is on bits 4:0, green on 9:5, red on 14:10, and bit 15 is 0.
- R6: With `fmt_sel`=3 (RGB 5:6:5), blue is on bits 4:0, the top 6 bits of green on 10:5, and red on 15:11.
- R7: When `blank_in`=1 and `vbi_in`=0, the bus carries fixed codes. In 16-bit YCbCr it is 0x1080. In 8-bit YCbCr the upper byte is 0x80 on even phases and 0x10 on odd phases. In either RGB format it is 0x0000.
- R8: When `blank_in`=1 and `vbi_in`=1, the samples are packed exactly as in active video for the selected format.
- R9: With `dv_gate`=0, `dvalid` is a level equal to the inverse of `blank_in` from the previous cycle, so it is never high on a cycle that follows a blanked sample.
- R10: With `dv_gate`=1, `dvalid` is that registered level ANDed with `clk2`. It is therefore low throughout the low half of every clock period.
- R11: `pix_out`, `blank_out`, `hsync_out`, `vsync_out` and `field_out` show the inputs from the previous rising edge of `clk2`, one register stage deep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | 2x pixel clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Output layout: 0 YCbCr 8-bit, 1 YCbCr 16-bit, 2 RGB 5:5:5, 3 RGB 5:6:5 |
| dv_gate | input | 1 | 0: level data-valid; 1: data-valid gated by clk2 |
| blank_in | input | 1 | Sample lies in a blanking interval |
| vbi_in | input | 1 | Ancillary data is present during blanking |
| hsync_in | input | 1 | Horizontal sync qualifier |
| vsync_in | input | 1 | Vertical sync qualifier |
| field_in | input | 1 | Field qualifier |
| y_in | input | COMP_W | Luma sample |
| cb_in | input | COMP_W | Blue-difference chroma sample |
| cr_in | input | COMP_W | Red-difference chroma sample |
| r_in | input | COMP_W | Red component |
| g_in | input | COMP_W | Green component |
| b_in | input | COMP_W | Blue component |
| pix_out | output | 16 | Packed pixel bus |
| blank_out | output | 1 | Registered blanking qualifier |
| hsync_out | output | 1 | Registered horizontal sync |
| vsync_out | output | 1 | Registered vertical sync |
| field_out | output | 1 | Registered field qualifier |
| dvalid | output | 1 | Data-valid, level or clock-gated |

## Verification
A phase register stuck or restarted at the wrong moment shows up on the multiplexed byte lane at the next sample. Affected lines would then open with Y or Cr instead of Cb, and in 16-bit YCbCr the chroma lane would carry Cr where Cb is due. Because the phase keeps counting through blanking, a miscount is also visible in the alternating 0x80/0x10 blank codes before any active sample arrives. A wrong previous-blank or data-valid register shows within one clock as `dvalid` disagreeing with the previous cycle's blanking. In gated mode it shows as `dvalid` being high during a low clock half.

// File: rtl/pof_pkg.sv
package pof_pkg;

    typedef enum logic [1:0] {
        FMT_YC8   = 2'd0,
        FMT_YC16  = 2'd1,
        FMT_RGB15 = 2'd2,
        FMT_RGB16 = 2'd3
    } fmt_e;

    localparam int BUS_W   = 16;
    localparam int LANE_W  = 8;
    localparam int RB_W    = 5;
    localparam int G6_W    = 6;

    localparam logic [LANE_W-1:0] LUMA_BLACK   = 8'd16;
    localparam logic [LANE_W-1:0] CHROMA_ZERO  = 8'd128;

    typedef struct packed {
        logic blank;
        logic hs;
        logic vs;
        logic fld;
        logic act;
    } qual_t;

    typedef logic [1:0] phase_t;

    function automatic logic [LANE_W-1:0] mux_lane(
        input phase_t           ph,
        input logic [LANE_W-1:0] y,
        input logic [LANE_W-1:0] cb,
        input logic [LANE_W-1:0] cr
    );
        logic [LANE_W-1:0] v;
        case (ph)
            2'd0:    v = cb;
            2'd2:    v = cr;
            default: v = y;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pof_msb.sv
module pof_msb #(
    parameter int IW = 8,
    parameter int OW = 5
) (
    input  logic [IW-1:0] d,
    output logic [OW-1:0] q
);
    generate
        if (IW == OW) begin : g_pass
            assign q = d;
        end else begin : g_slice
            assign q = d[IW-1 -: OW];
        end
    endgenerate
endmodule

// File: rtl/pof_phase.sv
module pof_phase
    import pof_pkg::*;
(
    input  logic   clk2,
    input  logic   rst,
    input  logic   blank_in,
    output phase_t sel
);
    logic   blank_d;
    phase_t ph_q;
    logic   line_start;

    assign line_start = blank_d & ~blank_in;
    assign sel        = line_start ? 2'd0 : ph_q;

    always_ff @(posedge clk2) begin
        if (rst) begin
            blank_d <= 1'b1;
            ph_q    <= 2'd0;
        end else begin
            blank_d <= blank_in;
            ph_q    <= sel + 2'd1;
        end
    end
endmodule

// File: rtl/pof_pack.sv
module pof_pack
    import pof_pkg::*;
#(
    parameter int COMP_W = 8
) (
    input  fmt_e              fmt,
    input  phase_t            sel,
    input  logic              blank,
    input  logic              vbi,
    input  logic [COMP_W-1:0] y,
    input  logic [COMP_W-1:0] cb,
    input  logic [COMP_W-1:0] cr,
    input  logic [COMP_W-1:0] r,
    input  logic [COMP_W-1:0] g,
    input  logic [COMP_W-1:0] b,
    output logic [BUS_W-1:0]  bus
);
    logic [LANE_W-1:0] y8, cb8, cr8;
    logic [RB_W-1:0]   r5, g5, b5;
    logic [G6_W-1:0]   g6;
    logic              force_black;
    logic [LANE_W-1:0] lane_hi, lane_c;

    pof_msb #(.IW(COMP_W), .OW(LANE_W)) u_y  (.d(y),  .q(y8));
    pof_msb #(.IW(COMP_W), .OW(LANE_W)) u_cb (.d(cb), .q(cb8));
    pof_msb #(.IW(COMP_W), .OW(LANE_W)) u_cr (.d(cr), .q(cr8));
    pof_msb #(.IW(COMP_W), .OW(RB_W))   u_r  (.d(r),  .q(r5));
    pof_msb #(.IW(COMP_W), .OW(RB_W))   u_g5 (.d(g),  .q(g5));
    pof_msb #(.IW(COMP_W), .OW(RB_W))   u_b  (.d(b),  .q(b5));
    pof_msb #(.IW(COMP_W), .OW(G6_W))   u_g6 (.d(g),  .q(g6));

    assign force_black = blank & ~vbi;

    always_comb begin
        if (force_black) begin
            lane_hi = mux_lane(sel, LUMA_BLACK, CHROMA_ZERO, CHROMA_ZERO);
            lane_c  = CHROMA_ZERO;
        end else begin
            lane_hi = mux_lane(sel, y8, cb8, cr8);
            lane_c  = sel[0] ? cr8 : cb8;
        end
    end

    always_comb begin
        bus = '0;
        case (fmt)
            FMT_YC8:   bus = {lane_hi, {LANE_W{1'b0}}};
            FMT_YC16:  bus = force_black ? {LUMA_BLACK, CHROMA_ZERO} : {y8, lane_c};
            FMT_RGB15: bus = force_black ? '0 : {1'b0, r5, g5, b5};
            FMT_RGB16: bus = force_black ? '0 : {r5, g6, b5};
            default:   bus = '0;
        endcase
    end
endmodule

// File: rtl/pof_oreg.sv
module pof_oreg
    import pof_pkg::*;
(
    input  logic             clk2,
    input  logic             rst,
    input  qual_t            q_d,
    input  logic [BUS_W-1:0] bus_d,
    output qual_t            q_q,
    output logic [BUS_W-1:0] bus_q
);
    always_ff @(posedge clk2) begin
        if (rst) begin
            q_q   <= '{blank: 1'b1, hs: 1'b0, vs: 1'b0, fld: 1'b0, act: 1'b0};
            bus_q <= '0;
        end else begin
            q_q   <= q_d;
            bus_q <= bus_d;
        end
    end
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
    import pof_pkg::*;
#(
    parameter int COMP_W = 8
) (
    input  logic              clk2,
    input  logic              rst,
    input  logic [1:0]        fmt_sel,
    input  logic              dv_gate,
    input  logic              blank_in,
    input  logic              vbi_in,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              field_in,
    input  logic [COMP_W-1:0] y_in,
    input  logic [COMP_W-1:0] cb_in,
    input  logic [COMP_W-1:0] cr_in,
    input  logic [COMP_W-1:0] r_in,
    input  logic [COMP_W-1:0] g_in,
    input  logic [COMP_W-1:0] b_in,
    output logic [15:0]       pix_out,
    output logic              blank_out,
    output logic              hsync_out,
    output logic              vsync_out,
    output logic              field_out,
    output logic              dvalid
);
    phase_t           sel;
    fmt_e             fmt;
    logic [BUS_W-1:0] bus_d;
    qual_t            q_d, q_q;

    assign fmt = fmt_e'(fmt_sel);

    pof_phase u_phase (
        .clk2     (clk2),
        .rst      (rst),
        .blank_in (blank_in),
        .sel      (sel)
    );

    pof_pack #(.COMP_W(COMP_W)) u_pack (
        .fmt   (fmt),
        .sel   (sel),
        .blank (blank_in),
        .vbi   (vbi_in),
        .y     (y_in),
        .cb    (cb_in),
        .cr    (cr_in),
        .r     (r_in),
        .g     (g_in),
        .b     (b_in),
        .bus   (bus_d)
    );

    assign q_d = '{blank: blank_in, hs: hsync_in, vs: vsync_in,
                   fld: field_in, act: ~blank_in};

    pof_oreg u_oreg (
        .clk2  (clk2),
        .rst   (rst),
        .q_d   (q_d),
        .bus_d (bus_d),
        .q_q   (q_q),
        .bus_q (pix_out)
    );

    assign blank_out = q_q.blank;
    assign hsync_out = q_q.hs;
    assign vsync_out = q_q.vs;
    assign field_out = q_q.fld;
    assign dvalid    = dv_gate ? (q_q.act & clk2) : q_q.act;
endmodule

// File: rtl/pof_chk.sv
module pof_chk #(
    parameter int COMP_W = 8
) (
    input logic              clk2,
    input logic              rst,
    input logic [1:0]        fmt_sel,
    input logic              dv_gate,
    input logic              blank_in,
    input logic              vbi_in,
    input logic              hsync_in,
    input logic [COMP_W-1:0] cb_in,
    input logic [15:0]       pix_out,
    input logic              blank_out,
    input logic              hsync_out,
    input logic              dvalid
);
    p_yc8_low_zero_r2: assert property (@(posedge clk2) disable iff (rst)
        !$past(rst) && $past(fmt_sel) == 2'd0 |-> pix_out[7:0] == 8'd0);

    p_rgb15_msb_r5: assert property (@(posedge clk2) disable iff (rst)
        !$past(rst) && $past(fmt_sel) == 2'd2 |-> !pix_out[15]);

    p_blank_codes_r7: assert property (@(posedge clk2) disable iff (rst)
        !$past(rst) && $past(blank_in && !vbi_in && fmt_sel == 2'd1)
        |-> pix_out == 16'h1080);

    p_first_cb_r3: assert property (@(posedge clk2) disable iff (rst)
        !$past(rst) && $past(fmt_sel == 2'd0 && !blank_in) && $past(blank_in, 2)
        |-> pix_out[15:8] == $past(cb_in[COMP_W-1 -: 8]));

    p_dv_level_r9: assert property (@(posedge clk2) disable iff (rst)
        !$past(rst) && !dv_gate |-> dvalid == !$past(blank_in));

    p_qual_delay_r11: assert property (@(posedge clk2) disable iff (rst)
        !$past(rst) |-> blank_out == $past(blank_in) && hsync_out == $past(hsync_in));
endmodule

bind pix_out_fmt pof_chk #(.COMP_W(COMP_W)) u_pof_chk (
    .clk2      (clk2),
    .rst       (rst),
    .fmt_sel   (fmt_sel),
    .dv_gate   (dv_gate),
    .blank_in  (blank_in),
    .vbi_in    (vbi_in),
    .hsync_in  (hsync_in),
    .cb_in     (cb_in),
    .pix_out   (pix_out),
    .blank_out (blank_out),
    .hsync_out (hsync_out),
    .dvalid    (dvalid)
);

// File: tb/test_pix_out_fmt.sv
`timescale 1ns/1ps
module test_pix_out_fmt;
    logic       clk2 = 1'b0;
    logic       rst;
    logic [1:0] fmt_sel;
    logic       dv_gate, blank_in, vbi_in, hsync_in, vsync_in, field_in;
    logic [7:0] y_in, cb_in, cr_in, r_in, g_in, b_in;
    logic [15:0] pix_out;
    logic       blank_out, hsync_out, vsync_out, field_out, dvalid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk2 = ~clk2;

    pix_out_fmt i_pix_out_fmt (
        .clk2(clk2), .rst(rst), .fmt_sel(fmt_sel), .dv_gate(dv_gate),
        .blank_in(blank_in), .vbi_in(vbi_in), .hsync_in(hsync_in),
        .vsync_in(vsync_in), .field_in(field_in),
        .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
        .r_in(r_in), .g_in(g_in), .b_in(b_in),
        .pix_out(pix_out), .blank_out(blank_out), .hsync_out(hsync_out),
        .vsync_out(vsync_out), .field_out(field_out), .dvalid(dvalid)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // bench model state
    logic [1:0] m_ph;
    logic       m_bd;

    function automatic logic [15:0] exp_bus(input logic [1:0] f, input logic [1:0] s,
                                            input logic bl, input logic vb,
                                            input logic [7:0] y, input logic [7:0] cb,
                                            input logic [7:0] cr, input logic [7:0] r,
                                            input logic [7:0] g, input logic [7:0] b);
        logic blk;
        logic [7:0] hi;
        blk = bl && !vb;
        case (f)
            2'd0: begin
                if (blk) hi = s[0] ? 8'd16 : 8'd128;
                else     hi = (s == 2'd0) ? cb : (s == 2'd2) ? cr : y;
                return {hi, 8'h00};
            end
            2'd1: return blk ? 16'h1080 : {y, (s[0] ? cr : cb)};
            2'd2: return blk ? 16'h0000 : {1'b0, r[7:3], g[7:3], b[7:3]};
            default: return blk ? 16'h0000 : {r[7:3], g[7:2], b[7:3]};
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] f, input logic bl, input logic vb);
        if (bl && !vb) return "R7";
        if (bl)        return "R8";
        case (f)
            2'd0: return "R2/R3";
            2'd1: return "R4/R3";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    int k = 0;

    // one cycle: drive now (clock high-to-low mid phase), check after next rising edge
    task automatic cycle(input logic bl, input logic vb);
        logic [1:0] s;
        logic [15:0] e;
        logic hs, vs, fl;
        k++;
        blank_in = bl; vbi_in = vb;
        y_in  = 8'((k * 37 + 5));
        cb_in = 8'((k * 11 + 64));
        cr_in = 8'((k * 23 + 200));
        r_in  = 8'((k * 13 + 1));
        g_in  = 8'((k * 29 + 7));
        b_in  = 8'((k * 17 + 3));
        hs = bl && (k % 3 == 0); vs = k[4]; fl = k[5];
        hsync_in = hs; vsync_in = vs; field_in = fl;
        s = (m_bd && !bl) ? 2'd0 : m_ph;
        e = exp_bus(fmt_sel, s, bl, vb, y_in, cb_in, cr_in, r_in, g_in, b_in);
        m_bd = bl;
        m_ph = s + 2'd1;
        @(posedge clk2);
        #1;
        check(req_of(fmt_sel, bl, vb), pix_out, e);
        check("R11 quals", {12'd0, blank_out, hsync_out, vsync_out, field_out},
              {12'd0, bl, hs, vs, fl});
        check(dv_gate ? "R10 high half" : "R9 level", {15'd0, dvalid}, {15'd0, !bl});
        #2.5;
        check(dv_gate ? "R10 low half" : "R9 level", {15'd0, dvalid},
              {15'd0, dv_gate ? 1'b0 : !bl});
    endtask

    task automatic run_segment(input int n, input logic bl, input logic vb);
        for (int i = 0; i < n; i++) cycle(bl, vb);
    endtask

    initial begin
        rst = 1'b1; fmt_sel = 2'd0; dv_gate = 1'b0;
        blank_in = 1'b0; vbi_in = 1'b0; hsync_in = 1'b1; vsync_in = 1'b1; field_in = 1'b1;
        y_in = 8'h55; cb_in = 8'h66; cr_in = 8'h77; r_in = 8'hff; g_in = 8'hff; b_in = 8'hff;
        m_ph = 2'd0; m_bd = 1'b1;
        repeat (3) @(posedge clk2);
        #1;
        check("R1 pix", pix_out, 16'h0000);
        check("R1 quals", {12'd0, blank_out, hsync_out, vsync_out, field_out}, 16'h0008);
        check("R1 dvalid", {15'd0, dvalid}, 16'h0000);
        #2.5;
        rst = 1'b0;
        for (int f = 0; f < 4; f++) begin
            for (int gt = 0; gt < 2; gt++) begin
                fmt_sel = 2'(f);
                dv_gate = gt[0];
                run_segment(5, 1'b1, 1'b0);
                run_segment(9, 1'b0, 1'b0);
                run_segment(3, 1'b1, 1'b1);
                run_segment(6, 1'b0, 1'b0);
                run_segment(2, 1'b1, 1'b0);
                run_segment(1, 1'b0, 1'b0);
                run_segment(3, 1'b1, 1'b1);
                run_segment(7, 1'b0, 1'b0);
            end
        end
        // format switch mid-line: phase keeps counting (R3)
        fmt_sel = 2'd0; dv_gate = 1'b0;
        run_segment(2, 1'b1, 1'b0);
        run_segment(3, 1'b0, 1'b0);
        fmt_sel = 2'd1;
        run_segment(3, 1'b0, 1'b0);
        fmt_sel = 2'd0;
        run_segment(3, 1'b0, 1'b0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule